// File: doc/BRIEF.md
# TDM Eight-Slot Serial Audio Receiver

This block takes a time-division-multiplexed audio stream from a codec that is the clock master. The codec drives the bit clock, the frame sync and the serial data. All three lines are brought into the system clock domain through a synchronizer. The receiver finds the falling edges of the bit clock and samples frame sync and data on those edges.

A frame holds eight slots of 32 bit clocks each. The block reads the 24-bit sample at the top of each slot and drops the low 8 bits. At the end of every slot whose enable bit is set, it presents the sample right-aligned and sign-extended to 32 bits, with a one-cycle valid strobe and the slot number. A frame sync that arrives in the middle of a frame does not change reception. It sets a sticky error flag, which the system clears with a pulse.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is held and right after it is released, `word_o` is zero, `slot_idx_o` is zero, `word_valid_o` is low and `frame_err_o` is low.
- R2: After reset, bits are discarded and no word is produced until frame sync has been seen high on a bit-clock falling edge.
- R3: The first data bit of a frame is the one sampled on the bit-clock falling edge that follows the edge where frame sync was seen high.
- R4: Frame sync and serial data are sampled only on falling edges of the bit clock. Data changes while the bit clock is high have no effect.
- R5: A frame is 8 slots of 32 bits. Slots are numbered 0 to 7 in arrival order, and `slot_idx_o` carries the number of the slot that produced the word.
- R6: The sample is bits 31 down to 8 of the slot, received MSB first. `word_o` equals the sample in bits 23:0, with bits 31:24 copies of bit 23.
- R7: Bit n of `slot_en_i` enables slot n. A disabled slot is still clocked through but raises no strobe.
- R8: A frame sync seen high before the last bit of the current frame is ignored. The frame's remaining slots are received unchanged.
- R9: An ignored frame sync sets `frame_err_o`. The flag stays set until `err_clr_i` is high on a clock edge. A new error on that same edge wins over the clear.
- R10: A frame sync seen high on the edge that samples a frame's last bit starts the next frame back to back. A frame that ends without one returns the receiver to waiting.
- R11: `word_valid_o` is high for exactly one clock per produced word. `word_o` and `slot_idx_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock from the external master |
| fsync_i | input | 1 | Frame sync, active high |
| sdata_i | input | 1 | Serial audio data |
| slot_en_i | input | 8 | Per-slot enable mask, bit n for slot n |
| err_clr_i | input | 1 | Clears the frame-error flag |
| word_o | output | 32 | Right-aligned, sign-extended sample |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| slot_idx_o | output | 3 | Slot number of the current word |
| frame_err_o | output | 1 | Sticky flag for an ignored mid-frame frame sync |

## Verification
The hardest case to reach is a frame sync at the exact boundary. On the edge that samples bit 255, a frame sync must start a new frame. On any earlier edge it must only set the error flag. The bench produces both cases from a single bit-stream task. That task takes a position at which to place frame sync inside a frame, and a choice of whether to place frame sync on the last bit. The bench then sends back-to-back frames, frames with a sync in the middle, and frames that end with no sync. Inside every bit period, the data line is briefly driven to the wrong value while the bit clock is high, so a receiver that samples on the wrong edge picks up bad data.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  typedef enum logic {
    RX_WAIT   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;

  typedef struct packed {
    logic bclk;
    logic fs;
    logic sd;
  } rx_lines_t;

endpackage

// File: rtl/tdmrx_sync.sv
module tdmrx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q[0] <= '0;
    end else begin
      stg_q[0] <= d_i;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[i] <= '0;
      end else begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/tdmrx_framer.sv
module tdmrx_framer
  import tdmrx_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32,
  parameter int SLOT_W    = 3,
  parameter int BIT_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fs_i,
  input  logic              err_clr_i,
  output logic              active_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic              slot_last_o,
  output logic              err_o
);

  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  rx_state_e         state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              err_q, err_d;
  logic              err_set;
  logic              at_slot_end;
  logic              at_frame_end;

  assign at_slot_end  = (bit_q == BIT_LAST);
  assign at_frame_end = at_slot_end && (slot_q == SLOT_LAST);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    err_set = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        RX_WAIT: begin
          if (fs_i) begin
            state_d = RX_ACTIVE;
            bit_d   = '0;
            slot_d  = '0;
          end
        end
        RX_ACTIVE: begin
          if (at_slot_end) begin
            bit_d = '0;
            if (at_frame_end) begin
              slot_d  = '0;
              state_d = fs_i ? RX_ACTIVE : RX_WAIT;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
          if (fs_i && !at_frame_end) begin
            err_set = 1'b1;
          end
        end
        default: state_d = RX_WAIT;
      endcase
    end
    err_d = err_set | (err_q & ~err_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_WAIT;
      bit_q   <= '0;
      slot_q  <= '0;
    end else if (tick_i) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign active_o    = (state_q == RX_ACTIVE);
  assign bit_idx_o   = bit_q;
  assign slot_idx_o  = slot_q;
  assign slot_last_o = tick_i && (state_q == RX_ACTIVE) && at_slot_end;
  assign err_o       = err_q;

endmodule

// File: rtl/tdmrx_deser.sv
module tdmrx_deser #(
  parameter int SLOTS       = 8,
  parameter int SAMPLE_BITS = 24,
  parameter int OUT_BITS    = 32,
  parameter int SLOT_W      = 3,
  parameter int BIT_W       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                active_i,
  input  logic                sd_i,
  input  logic [BIT_W-1:0]    bit_idx_i,
  input  logic                slot_last_i,
  input  logic [SLOT_W-1:0]   slot_idx_i,
  input  logic [SLOTS-1:0]    slot_en_i,
  output logic [OUT_BITS-1:0] word_o,
  output logic                valid_o,
  output logic [SLOT_W-1:0]   idx_o
);

  localparam int            EXT_BITS   = OUT_BITS - SAMPLE_BITS;
  localparam logic [BIT_W:0] SAMPLE_LIM = (BIT_W+1)'(SAMPLE_BITS);

  logic [SAMPLE_BITS-1:0] sr_q, sr_d;
  logic                   shift_en;
  logic                   hit;
  logic [OUT_BITS-1:0]    word_d;
  logic [OUT_BITS-1:0]    word_q;
  logic [SLOT_W-1:0]      idx_q;
  logic                   valid_q;

  always_comb begin
    shift_en = tick_i && active_i && ({1'b0, bit_idx_i} < SAMPLE_LIM);
    sr_d     = shift_en ? {sr_q[SAMPLE_BITS-2:0], sd_i} : sr_q;
    hit      = slot_last_i && slot_en_i[slot_idx_i];
    word_d   = {{EXT_BITS{sr_d[SAMPLE_BITS-1]}}, sr_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (hit) begin
      word_q <= word_d;
      idx_q  <= slot_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= hit;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdmrx_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24,
  parameter int OUT_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sdata_i,
  input  logic [SLOTS-1:0]    slot_en_i,
  input  logic                err_clr_i,
  output logic [OUT_BITS-1:0] word_o,
  output logic                word_valid_o,
  output logic [SLOT_W-1:0]   slot_idx_o,
  output logic                frame_err_o
);

  localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  rx_lines_t         raw_lines;
  rx_lines_t         sync_lines;
  logic              bclk_prev_q;
  logic              fall_tick;
  logic              active;
  logic [BIT_W-1:0]  bit_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_last;

  assign raw_lines = '{bclk: bclk_i, fs: fsync_i, sd: sdata_i};

  tdmrx_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  ($bits(rx_lines_t))
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_lines),
    .q_o    (sync_lines)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_prev_q <= 1'b0;
    end else begin
      bclk_prev_q <= sync_lines.bclk;
    end
  end

  assign fall_tick = bclk_prev_q && !sync_lines.bclk;

  tdmrx_framer #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .SLOT_W    (SLOT_W),
    .BIT_W     (BIT_W)
  ) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (fall_tick),
    .fs_i        (sync_lines.fs),
    .err_clr_i   (err_clr_i),
    .active_o    (active),
    .bit_idx_o   (bit_idx),
    .slot_idx_o  (slot_idx),
    .slot_last_o (slot_last),
    .err_o       (frame_err_o)
  );

  tdmrx_deser #(
    .SLOTS       (SLOTS),
    .SAMPLE_BITS (SAMPLE_BITS),
    .OUT_BITS    (OUT_BITS),
    .SLOT_W      (SLOT_W),
    .BIT_W       (BIT_W)
  ) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (fall_tick),
    .active_i    (active),
    .sd_i        (sync_lines.sd),
    .bit_idx_i   (bit_idx),
    .slot_last_i (slot_last),
    .slot_idx_i  (slot_idx),
    .slot_en_i   (slot_en_i),
    .word_o      (word_o),
    .valid_o     (word_valid_o),
    .idx_o       (slot_idx_o)
  );

endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
  parameter int SLOTS       = 8,
  parameter int SAMPLE_BITS = 24,
  parameter int OUT_BITS    = 32,
  parameter int SLOT_W      = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SLOTS-1:0]    slot_en_i,
  input logic                err_clr_i,
  input logic [OUT_BITS-1:0] word_o,
  input logic                word_valid_o,
  input logic [SLOT_W-1:0]   slot_idx_o,
  input logic                frame_err_o
);

  logic [SLOTS-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      en_q <= slot_en_i;
    end
  end

  // R11: the strobe never lasts two cycles
  assert_strobe_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R11: the word holds between strobes
  assert_word_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> ($stable(word_o) && $stable(slot_idx_o)));

  // R6: the upper bits copy the sample sign bit
  assert_sign_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ((word_o[OUT_BITS-1:SAMPLE_BITS-1] == '0) ||
                      (word_o[OUT_BITS-1:SAMPLE_BITS-1] == '1)));

  // R7: a strobe only for a slot that was enabled
  assert_enabled_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> en_q[slot_idx_o]);

  // R9: the error flag is sticky until cleared
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !err_clr_i) |=> frame_err_o);

endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(
  .SLOTS       (SLOTS),
  .SAMPLE_BITS (SAMPLE_BITS),
  .OUT_BITS    (OUT_BITS),
  .SLOT_W      (SLOT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_en_i    (slot_en_i),
  .err_clr_i    (err_clr_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .slot_idx_o   (slot_idx_o),
  .frame_err_o  (frame_err_o)
);

// File: tb/tdm_slot_rx_test.sv
`timescale 1ns/1ps
module tdm_slot_rx_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk;
  logic        fsync;
  logic        sdata;
  logic [7:0]  slot_en;
  logic        err_clr;
  logic [31:0] word;
  logic        valid;
  logic [2:0]  sidx;
  logic        ferr;

  tdm_slot_rx uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bclk_i       (bclk),
    .fsync_i      (fsync),
    .sdata_i      (sdata),
    .slot_en_i    (slot_en),
    .err_clr_i    (err_clr),
    .word_o       (word),
    .word_valid_o (valid),
    .slot_idx_o   (sidx),
    .frame_err_o  (ferr)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int n_words = 0;
  int run     = 0;
  int max_run = 0;
  logic [31:0] wq[$];
  int          iq[$];
  logic [31:0] fw[8];

  // behavioural reference
  bit          hb[3];
  bit          hf[3];
  bit          hd[3];
  bit          m_act;
  int          m_pos;
  logic [31:0] m_acc;
  bit          m_valid;
  logic [31:0] m_word;
  int          m_idx;
  bit          m_err;

  always @(posedge clk) begin
    bit fall, f, d, setv;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin hb[i] = 0; hf[i] = 0; hd[i] = 0; end
      m_act = 0; m_pos = 0; m_acc = '0; m_valid = 0;
      m_word = '0; m_idx = 0; m_err = 0;
    end else begin
      fall = hb[2] && !hb[1];
      f = hf[1];
      d = hd[1];
      m_valid = 0;
      setv = 0;
      if (fall) begin
        if (m_act) begin
          m_acc = {m_acc[30:0], d};
          if ((m_pos % 32) == 31 && slot_en[m_pos / 32]) begin
            m_valid = 1;
            m_word  = {{8{m_acc[31]}}, m_acc[31:8]};
            m_idx   = m_pos / 32;
          end
          if (m_pos == 255) begin
            m_act = f;
            m_pos = 0;
          end else begin
            if (f) setv = 1;
            m_pos++;
          end
        end else if (f) begin
          m_act = 1;
          m_pos = 0;
        end
      end
      if (setv) m_err = 1;
      else if (err_clr) m_err = 0;
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = bclk;
      hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = fsync;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = sdata;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (valid !== m_valid) begin
        fails++;
        $display("FAIL R7 strobe: actual %0b expected %0b", valid, m_valid);
      end
      if (word !== m_word) begin
        fails++;
        $display("FAIL R6 word: actual %h expected %h", word, m_word);
      end
      if (int'(sidx) !== m_idx) begin
        fails++;
        $display("FAIL R5 slot index: actual %0d expected %0d", sidx, m_idx);
      end
      if (ferr !== m_err) begin
        fails++;
        $display("FAIL R9 error flag: actual %0b expected %0b", ferr, m_err);
      end
      if (valid) begin
        n_words++;
        wq.push_back(word);
        iq.push_back(int'(sidx));
        run++;
        if (run > max_run) max_run = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R5 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bit period of 8 system clocks; data is wrong early in the high phase
  task automatic send_bit(input bit f, input bit d);
    bclk  = 1'b1;
    fsync = f;
    sdata = ~d;
    repeat (2) @(negedge clk);
    sdata = d;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int glitch, input bit fs_end);
    for (int b = 0; b < 256; b++) begin
      send_bit((b == glitch) || (b == 255 && fs_end), fw[b / 32][31 - (b % 32)]);
    end
  endtask

  task automatic clear_log();
    n_words = 0;
    wq.delete();
    iq.delete();
  endtask

  task automatic rand_words();
    for (int s = 0; s < 8; s++) fw[s] = $urandom;
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
    slot_en = 8'hFF; err_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 word after reset", word, 32'h0);
    check("R1 strobe after reset", {31'h0, valid}, 32'h0);
    check("R1 index after reset", {29'h0, sidx}, 32'h0);
    check("R1 error after reset", {31'h0, ferr}, 32'h0);

    // R2 bits before any frame sync are dropped
    clear_log();
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'($urandom));
    check("R2 words before first sync", n_words, 0);

    // R3, R4, R5, R6 directed frame, ends with sync for a back-to-back frame
    fw[0] = 32'h12345678; fw[1] = 32'h80000000; fw[2] = 32'h7FFFFFFF;
    fw[3] = 32'h000000FF; fw[4] = 32'hFFFFFF00; fw[5] = 32'h00800000;
    fw[6] = 32'hA5A5A5A5; fw[7] = 32'h7FFFFF80;
    clear_log();
    send_bit(1'b1, 1'b1);
    send_frame(-1, 1'b1);
    check("R5 words per frame", n_words, 8);
    if (wq.size() == 8) begin
      check("R3 first slot alignment", wq[0], 32'h00123456);
      check("R6 negative full scale", wq[1], 32'hFF800000);
      check("R6 positive full scale", wq[2], 32'h007FFFFF);
      check("R6 low byte dropped", wq[3], 32'h00000000);
      check("R6 minus one", wq[4], 32'hFFFFFFFF);
      check("R6 mid value", wq[5], 32'h00008000);
      check("R4 falling-edge sampling", wq[6], 32'hFFA5A5A5);
      check("R6 top sample", wq[7], 32'h007FFFFF);
      for (int k = 0; k < 8; k++) check("R5 slot order", iq[k], k);
    end

    // R7 and R10: back-to-back frame with a sparse mask, no sync at its end
    slot_en = 8'hA5;
    rand_words();
    clear_log();
    send_frame(-1, 1'b0);
    check("R10 back-to-back frame words", n_words, 4);
    if (iq.size() == 4) begin
      check("R7 first enabled slot", iq[0], 0);
      check("R7 second enabled slot", iq[1], 2);
      check("R7 third enabled slot", iq[2], 5);
      check("R7 fourth enabled slot", iq[3], 7);
    end

    // R10: after a frame with no closing sync the receiver waits
    clear_log();
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'($urandom));
    check("R10 idle after unterminated frame", n_words, 0);

    // R8, R9: a sync in the middle of a frame is ignored but flagged
    slot_en = 8'hFF;
    rand_words();
    clear_log();
    send_bit(1'b1, 1'b0);
    send_frame(100, 1'b0);
    check("R8 words despite mid-frame sync", n_words, 8);
    if (iq.size() == 8) check("R8 last slot index", iq[7], 7);
    check("R9 error set", {31'h0, ferr}, 32'h1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    check("R9 error sticky", {31'h0, ferr}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    check("R9 error cleared", {31'h0, ferr}, 32'h0);

    // R10: two random back-to-back frames
    clear_log();
    rand_words();
    send_bit(1'b1, 1'b1);
    send_frame(-1, 1'b1);
    rand_words();
    send_frame(-1, 1'b0);
    check("R10 two chained frames", n_words, 16);
    check("R11 strobe length", max_run, 1);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule